// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block gathers the interrupt sources of a small 8-bit processor core into one control/status register. Three events can raise a flag: a one-cycle overflow pulse from the timer, a selected edge on the external interrupt pin, and a mismatch between three watched input pins and a copy of them that is refreshed whenever software reads the pin port. Each flag has its own enable, and a global enable sits above them.

Software reads and writes the register over a plain register-bus port. The block drives two outputs. `irq_o` asks the core to branch to the interrupt vector. `wake_o` pulls the core out of sleep. Wake-up depends only on the flags and their own enables, so a core with the global enable off wakes and carries on with the next instruction. When the core takes the interrupt it pulses `irq_take`, which drops the global enable. The block saves no context; the core keeps only its return address.

Top module: `irq_flag_ctl`

## Requirements
- R1: After reset the register reads 0x00 and both `irq_o` and `wake_o` are low.
- R2: A high `tmr_ovf` during a clock edge sets bit 2 (timer flag) at that edge. Bit 5 is the timer enable.
- R3: The external pin passes through two synchroniser flops. With `edge_rising`=1 a low-to-high transition sets bit 1 (external flag) at the third clock edge after the pin changes. With `edge_rising`=0 a high-to-low transition does the same. The opposite transition leaves bit 1 unchanged. Bit 4 is the external enable.
- R4: Once set, the external flag stays set until a register write puts 0 in bit 1.
- R5: While any of the three synchronised watched pins differs from the latched copy, bit 0 (change flag) is set. A mismatch shows at the third edge after the pin moves. A `port_rd` pulse loads the copy from the synchronised pins at that edge. After the reload, a write of 0 to bit 0 clears the flag and it stays clear. Bit 3 is the change enable.
- R6: `irq_o` is high exactly when bit 7 (global enable) is set and at least one flag has its enable set.
- R7: `irq_take` clears the global enable at the edge. This takes priority over a write in the same cycle, so `irq_o` is low afterwards.
- R8: `wake_o` is high whenever at least one flag has its enable set, whatever the global enable is.
- R9: A hardware event that sets a flag in the same cycle as a register write wins over the written value for that flag.
- R10: A write loads bits 7, 5, 4, 3, 2, 1 and 0 from `reg_wdata`. Bit 6 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_ovf | input | 1 | Timer rollover pulse, one cycle |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| edge_rising | input | 1 | 1: rising edge counts, 0: falling edge counts |
| watch_pins | input | 3 | Pins watched for a change, asynchronous |
| port_rd | input | 1 | Software read of the pin port; reloads the change copy |
| port_rdata | output | 3 | Synchronised watched pins |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_take | input | 1 | Core has taken the interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| wake_o | output | 1 | Wake request to the sleeping core |

## Verification
Register writes, the timer pulse and `irq_take` act at the very next edge. `irq_o` and `wake_o` follow the register with no further delay. The external edge and the pin change need three edges: two synchroniser stages and the flag register. The bench drives inputs on falling edges and samples on falling edges. For the synchronised paths it checks once after the second rising edge, where the flag must still be clear, and again after the third, where it must be set. A wrong synchroniser depth therefore shows up in one of the two checks.

// File: rtl/irq_flag_ctl.sv
module irq_flag_ctl #(
  parameter int NWATCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic              edge_rising,
  input  logic [NWATCH-1:0] watch_pins,
  input  logic              port_rd,
  output logic [NWATCH-1:0] port_rdata,
  input  logic              reg_we,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              irq_take,
  output logic              irq_o,
  output logic              wake_o
);
  logic [1:0]        ext_sync;
  logic              ext_prev;
  logic [NWATCH-1:0] w_meta, w_sync, w_copy;
  logic [2:0]        flags, enables, hw_set, pending;
  logic              gie, ext_edge, changed;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_sync <= '0;
      ext_prev <= 1'b0;
      w_meta   <= '0;
      w_sync   <= '0;
      w_copy   <= '0;
    end else begin
      ext_sync <= {ext_sync[0], ext_pin};
      ext_prev <= ext_sync[1];
      w_meta   <= watch_pins;
      w_sync   <= w_meta;
      if (port_rd) w_copy <= w_sync;
    end

  assign ext_edge   = edge_rising ? (ext_sync[1] & ~ext_prev) : (~ext_sync[1] & ext_prev);
  assign changed    = |(w_sync ^ w_copy);
  assign hw_set     = {tmr_ovf, ext_edge, changed};
  assign port_rdata = w_sync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
      gie     <= 1'b0;
    end else begin
      if (reg_we) begin
        flags   <= reg_wdata[2:0] | hw_set;
        enables <= reg_wdata[5:3];
      end else begin
        flags   <= flags | hw_set;
      end
      if (irq_take)    gie <= 1'b0;
      else if (reg_we) gie <= reg_wdata[7];
    end

  assign pending   = flags & enables;
  assign irq_o     = gie & (|pending);
  assign wake_o    = |pending;
  assign reg_rdata = {gie, 1'b0, enables, flags};

  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> reg_rdata[2]);
  p_ext_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[1] && !reg_we) |=> reg_rdata[1]);
  p_take_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> (!irq_o && !reg_rdata[7]));
  p_hw_beats_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[2] && tmr_ovf) |=> reg_rdata[2]);
  p_bit6_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_rdata[6]);
  p_wake_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we && reg_rdata[5:3] == 3'b000) |=> !wake_o);
endmodule

// File: tb/irq_flag_ctl_test.sv
module irq_flag_ctl_test;
  logic clk = 0, rst_n = 0;
  logic tmr_ovf = 0, ext_pin = 0, edge_rising = 1, port_rd = 0;
  logic [2:0] watch_pins = 0, port_rdata;
  logic reg_we = 0, irq_take = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_o, wake_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  irq_flag_ctl uut (.clk, .rst_n, .tmr_ovf, .ext_pin, .edge_rising, .watch_pins,
    .port_rd, .port_rdata, .reg_we, .reg_wdata, .reg_rdata, .irq_take, .irq_o, .wake_o);

  // {we, wdata[8], tmr, exp_rd[8], exp_irq, exp_wake}
  localparam logic [19:0] VEC [8] = '{
    {1'b1, 8'h20, 1'b0, 8'h20, 1'b0, 1'b0},  // R10 enable write
    {1'b0, 8'h00, 1'b1, 8'h24, 1'b0, 1'b1},  // R2, R8
    {1'b1, 8'hA4, 1'b0, 8'hA4, 1'b1, 1'b1},  // R6
    {1'b1, 8'h80, 1'b0, 8'h80, 1'b0, 1'b0},  // R6 cleared
    {1'b1, 8'h80, 1'b1, 8'h84, 1'b0, 1'b0},  // R9
    {1'b1, 8'hE4, 1'b0, 8'hA4, 1'b1, 1'b1},  // R10 bit 6
    {1'b1, 8'h3F, 1'b0, 8'h3F, 1'b0, 1'b1},  // R8 gie off
    {1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_wdata = d; tick(); reg_we = 0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1;
    tick();
    check("R1", {reg_rdata, irq_o, wake_o}, 10'h000);

    foreach (VEC[i]) begin
      reg_we = VEC[i][19]; reg_wdata = VEC[i][18:11]; tmr_ovf = VEC[i][10];
      tick();
      reg_we = 0; tmr_ovf = 0;
      check($sformatf("R2/R6/R8/R9/R10 vec%0d", i), {reg_rdata, irq_o, wake_o}, VEC[i][9:0]);
    end

    // R3 rising edge, three-edge latency
    edge_rising = 1; wr(8'h90);
    ext_pin = 1; tick(2);
    check("R3 rise early", {9'b0, reg_rdata[1]}, 10'h0);
    tick();
    check("R3 rise", {8'h00, reg_rdata[1], irq_o}, 10'h3);
    // R4 sticky through the opposite edge
    ext_pin = 0; tick(5);
    check("R4 sticky", {9'b0, reg_rdata[1]}, 10'h1);
    wr(8'h90);
    check("R4 clear", {9'b0, reg_rdata[1]}, 10'h0);
    // R3 falling mode: rising ignored, falling counts
    edge_rising = 0; ext_pin = 1; tick(5);
    check("R3 rise ignored", {9'b0, reg_rdata[1]}, 10'h0);
    ext_pin = 0; tick(2);
    check("R3 fall early", {9'b0, reg_rdata[1]}, 10'h0);
    tick();
    check("R3 fall", {9'b0, reg_rdata[1]}, 10'h1);

    // R5 change detect
    wr(8'h00);
    watch_pins = 3'b010; tick(2);
    check("R5 early", {9'b0, reg_rdata[0]}, 10'h0);
    tick();
    check("R5 set", {7'b0, port_rdata}, {7'b0, 3'b010});
    check("R5 flag", {9'b0, reg_rdata[0]}, 10'h1);
    wr(8'h00); tick(2);
    check("R5 mismatch holds", {9'b0, reg_rdata[0]}, 10'h1);
    port_rd = 1; tick(); port_rd = 0;
    wr(8'h00); tick(4);
    check("R5 cleared after reload", {9'b0, reg_rdata[0]}, 10'h0);

    // R7 take drops gie, wake stays
    wr(8'h88);
    watch_pins = 3'b011; tick(3);
    check("R7 irq up", {8'h00, irq_o, wake_o}, 10'h3);
    irq_take = 1; reg_we = 1; reg_wdata = 8'h88; tick(); irq_take = 0; reg_we = 0;
    check("R7 taken", {reg_rdata[7], 7'b0, irq_o, wake_o}, 10'h001);

    // R1 reset again
    rst_n = 0; tick(); 
    check("R1 reset", {reg_rdata, irq_o, wake_o}, 10'h000);
    rst_n = 1; tick();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule